// File: doc/BRIEF.md
# Software-Loaded Address Translation Unit

This block sits between a pipelined CPU data port and a downstream memory bus and turns virtual word addresses into physical ones. Translation uses a small fully associative table of page entries. Software fills the table, and sets the current address-space identifier, through a separate register port. In user mode every request is looked up in the table, checked against the current identifier and against the page permissions, and then either forwarded with the physical page number substituted, or refused with a one-cycle miss pulse that is kept apart from bus errors. In kernel mode requests pass straight through.

The lookup is a single combinational compare of all entries, done in the cycle the CPU strobe is accepted. The downstream request is registered, so every request reaches the memory bus one cycle after it is accepted. Requests to the same page, or to different pages, stream at one per clock. A stall from the memory bus is passed back to the CPU, and the held request stays frozen until the stall clears. After a refused request, software reads a status word that holds the faulting page and the cause.

Each table entry has a virtual word and a physical word. The address-space identifier of an entry is split across the two words. An entry becomes usable only once its physical word is written.

Top module: `xlat_mmu`

## Requirements
- R1: The register port acknowledges every strobe on the next cycle, with read data. Register word 0 reads {LG_ADDR-17 in bits 31:28, LG_TLB in 27:24, LG_PAGE-10 in 23:20, CTX_BITS-1 in 19:16, identifier in 15:0}. Only bits 15:0 are writable, and they read back as written.
- R2: Entry K has its virtual word at byte offset (8<<LG_TLB)+8K and its physical word 4 bytes higher. The virtual word is {page number above bit LG_PAGE-1, identifier low part in bits LG_PAGE-1:4, flags in 3:0}: bit 3 read-only, bit 2 executable, bit 1 cachable, bit 0 accessed. The physical word is {page number, identifier high part in bits LG_PAGE-1:4, 0000}.
- R3: Writing the physical word of an entry makes it valid. Writing the virtual word of an entry makes it invalid. An invalid entry never matches.
- R4: With user_mode low, an accepted request appears on the memory bus on the next cycle with the address unchanged, and is never refused.
- R5: With user_mode high, a request matches an entry when the entry is valid, its virtual page equals the request page, and its split identifier equals the current identifier. The forwarded address is the physical page joined with the page offset. When several entries match, the lowest index wins.
- R6: A user-mode request that matches no entry raises cpu_miss for one cycle, on the cycle after acceptance. No memory strobe is issued for it, and the memory cycle is not opened for it.
- R7: A user-mode write that matches a read-only entry is refused as in R6.
- R8: A user-mode request with fetch high that matches an entry without the executable flag is refused as in R6. A read of a read-only page is allowed.
- R9: The status word at byte offset 4 holds the faulting virtual page in bits 31:LG_PAGE, and in bits 2:0 a one-hot cause: 1 no match, 2 read-only write, 4 no execute. It holds until the next refusal.
- R10: A forwarded user-mode request sets the accessed flag of the entry it matched. A software write to that entry's virtual word in the same cycle takes precedence.
- R11: cpu_stall is high exactly while a forwarded request waits under mem_stall, and the held request stays unchanged. Without a memory stall, back-to-back requests are forwarded one per clock.
- R12: cpu_ack and cpu_err follow mem_ack and mem_err while the memory cycle is open. The memory cycle opens with the first forwarded request and closes on the cycle after cpu_cyc falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_stb | input | 1 | Register port strobe |
| ctl_we | input | 1 | Register port write enable |
| ctl_addr | input | LG_TLB+2 | Register word address |
| ctl_wdata | input | 32 | Register write data |
| ctl_ack | output | 1 | Register access acknowledge |
| ctl_rdata | output | 32 | Register read data |
| cpu_cyc | input | 1 | CPU bus cycle |
| cpu_stb | input | 1 | CPU request strobe |
| cpu_we | input | 1 | CPU write |
| cpu_addr | input | LG_ADDR-2 | CPU virtual word address |
| cpu_wdata | input | 32 | CPU write data |
| cpu_sel | input | 4 | CPU byte selects |
| user_mode | input | 1 | High selects translated, checked access |
| cpu_fetch | input | 1 | Request is an instruction fetch |
| cpu_stall | output | 1 | Hold off new strobes |
| cpu_ack | output | 1 | Request completed |
| cpu_miss | output | 1 | Translation or permission refusal |
| cpu_err | output | 1 | Bus error from memory |
| cpu_rdata | output | 32 | Read data to CPU |
| mem_cyc | output | 1 | Memory bus cycle |
| mem_stb | output | 1 | Memory request strobe |
| mem_we | output | 1 | Memory write |
| mem_addr | output | LG_ADDR-2 | Physical word address |
| mem_wdata | output | 32 | Memory write data |
| mem_sel | output | 4 | Memory byte selects |
| mem_stall | input | 1 | Memory stall |
| mem_ack | input | 1 | Memory acknowledge |
| mem_err | input | 1 | Memory bus error |
| mem_rdata | input | 32 | Memory read data |

## Verification
Two functions can act on the same entry in one cycle: a user-mode hit that sets the accessed flag of an entry, and a software write to that entry's virtual word. The bench provokes this by driving a register-port write of entry 0 and a user-mode read of entry 0's page on the same clock edge. It then reads the virtual word back and expects exactly the value written, with the accessed flag clear. A second overlap is a memory stall arriving while a same-page burst is streaming. There the cycle-level model checks that the held address does not move and that the burst resumes at one request per clock.

// File: rtl/mmu_pkg.sv
package mmu_pkg;
  typedef enum logic [2:0] {
    FLT_NONE    = 3'b000,
    FLT_NOMATCH = 3'b001,
    FLT_ROWRITE = 3'b010,
    FLT_NOEXEC  = 3'b100
  } fault_e;

  localparam int FLAG_RO = 3;
  localparam int FLAG_EX = 2;
  localparam int FLAG_AX = 0;
endpackage

// File: rtl/tlb_store.sv
module tlb_store #(
  parameter int N_ENT = 8,
  parameter int IDX_W = 3,
  parameter int VPN_W = 20,
  parameter int CLO_W = 8,
  parameter int CHI_W = 8
) (
  input  logic                                  clk,
  input  logic                                  arst_n,
  input  logic                                  sw_we,
  input  logic                                  sw_phys,
  input  logic [IDX_W-1:0]                      sw_idx,
  input  logic [31:0]                           sw_wdata,
  input  logic                                  ax_set,
  input  logic [IDX_W-1:0]                      ax_idx,
  output logic [N_ENT-1:0]                      valid,
  output logic [N_ENT-1:0][VPN_W-1:0]           vpn,
  output logic [N_ENT-1:0][VPN_W-1:0]           ppn,
  output logic [N_ENT-1:0][CLO_W+CHI_W-1:0]     ctx,
  output logic [N_ENT-1:0][3:0]                 flags,
  output logic [31:0]                           rd_vword,
  output logic [31:0]                           rd_pword
);
  localparam int PG = CLO_W + 4;

  logic [N_ENT-1:0]            valid_q, valid_d;
  logic [N_ENT-1:0][VPN_W-1:0] vpn_q, vpn_d, ppn_q, ppn_d;
  logic [N_ENT-1:0][CLO_W-1:0] clo_q, clo_d;
  logic [N_ENT-1:0][CHI_W-1:0] chi_q, chi_d;
  logic [N_ENT-1:0][3:0]       flg_q, flg_d;

  always_comb begin
    valid_d = valid_q;
    vpn_d   = vpn_q;
    ppn_d   = ppn_q;
    clo_d   = clo_q;
    chi_d   = chi_q;
    flg_d   = flg_q;
    if (ax_set) flg_d[ax_idx][mmu_pkg::FLAG_AX] = 1'b1;
    if (sw_we) begin
      if (sw_phys) begin
        ppn_d[sw_idx]   = sw_wdata[PG +: VPN_W];
        chi_d[sw_idx]   = sw_wdata[4 +: CHI_W];
        valid_d[sw_idx] = 1'b1;
      end else begin
        vpn_d[sw_idx]   = sw_wdata[PG +: VPN_W];
        clo_d[sw_idx]   = sw_wdata[4 +: CLO_W];
        flg_d[sw_idx]   = sw_wdata[3:0];
        valid_d[sw_idx] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      valid_q <= '0;
      vpn_q   <= '0;
      ppn_q   <= '0;
      clo_q   <= '0;
      chi_q   <= '0;
      flg_q   <= '0;
    end else begin
      valid_q <= valid_d;
      vpn_q   <= vpn_d;
      ppn_q   <= ppn_d;
      clo_q   <= clo_d;
      chi_q   <= chi_d;
      flg_q   <= flg_d;
    end
  end

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    assign ctx[g] = {chi_q[g], clo_q[g]};
  end
  assign valid = valid_q;
  assign vpn   = vpn_q;
  assign ppn   = ppn_q;
  assign flags = flg_q;

  always_comb begin
    rd_vword = '0;
    rd_vword[PG +: VPN_W] = vpn_q[sw_idx];
    rd_vword[4 +: CLO_W]  = clo_q[sw_idx];
    rd_vword[3:0]         = flg_q[sw_idx];
    rd_pword = '0;
    rd_pword[PG +: VPN_W] = ppn_q[sw_idx];
    rd_pword[4 +: CHI_W]  = chi_q[sw_idx];
  end

  AST_VWRITE_INVALIDATES: assert property (@(posedge clk) disable iff (!arst_n)
    (sw_we && !sw_phys) |=> !valid[$past(sw_idx)]); // R3
  AST_PWRITE_VALIDATES: assert property (@(posedge clk) disable iff (!arst_n)
    (sw_we && sw_phys) |=> valid[$past(sw_idx)]); // R3
endmodule

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int N_ENT = 8,
  parameter int IDX_W = 3,
  parameter int VPN_W = 20,
  parameter int CTX_W = 16
) (
  input  logic [N_ENT-1:0]              valid,
  input  logic [N_ENT-1:0][VPN_W-1:0]   vpn,
  input  logic [N_ENT-1:0][CTX_W-1:0]   ctx,
  input  logic [VPN_W-1:0]              look_vpn,
  input  logic [CTX_W-1:0]              look_ctx,
  output logic                          hit,
  output logic [IDX_W-1:0]              hit_idx
);
  logic [N_ENT-1:0] m;

  for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
    assign m[g] = valid[g] && (vpn[g] == look_vpn) && (ctx[g] == look_ctx);
  end

  always_comb begin
    hit     = |m;
    hit_idx = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (m[i]) hit_idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/xlat_mmu.sv
module xlat_mmu #(
  parameter int LG_ADDR  = 32,
  parameter int LG_TLB   = 3,
  parameter int LG_PAGE  = 12,
  parameter int CTX_BITS = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ctl_stb,
  input  logic                  ctl_we,
  input  logic [LG_TLB+1:0]     ctl_addr,
  input  logic [31:0]           ctl_wdata,
  output logic                  ctl_ack,
  output logic [31:0]           ctl_rdata,
  input  logic                  cpu_cyc,
  input  logic                  cpu_stb,
  input  logic                  cpu_we,
  input  logic [LG_ADDR-3:0]    cpu_addr,
  input  logic [31:0]           cpu_wdata,
  input  logic [3:0]            cpu_sel,
  input  logic                  user_mode,
  input  logic                  cpu_fetch,
  output logic                  cpu_stall,
  output logic                  cpu_ack,
  output logic                  cpu_miss,
  output logic                  cpu_err,
  output logic [31:0]           cpu_rdata,
  output logic                  mem_cyc,
  output logic                  mem_stb,
  output logic                  mem_we,
  output logic [LG_ADDR-3:0]    mem_addr,
  output logic [31:0]           mem_wdata,
  output logic [3:0]            mem_sel,
  input  logic                  mem_stall,
  input  logic                  mem_ack,
  input  logic                  mem_err,
  input  logic [31:0]           mem_rdata
);
  import mmu_pkg::*;

  localparam int AW     = LG_ADDR - 2;
  localparam int VPN_W  = LG_ADDR - LG_PAGE;
  localparam int OFF_W  = LG_PAGE - 2;
  localparam int N_ENT  = 1 << LG_TLB;
  localparam int CLO_W  = LG_PAGE - 4;
  localparam int CHI_W  = CTX_BITS - CLO_W;
  localparam int CTL_AW = LG_TLB + 2;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       arst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign arst_n = rst_pipe[1];

  // state
  logic             stb_q, stb_d, cyc_q, cyc_d, we_q, we_d, miss_q, miss_d;
  logic [AW-1:0]    addr_q, addr_d;
  logic [31:0]      wdat_q, wdat_d;
  logic [3:0]       sel_q, sel_d;
  logic [15:0]      ctx_q, ctx_d;
  logic [VPN_W-1:0] st_vpn_q, st_vpn_d;
  logic [2:0]       st_cause_q, st_cause_d;
  logic             cack_q, cack_d;
  logic [31:0]      crd_q, crd_d;

  // table
  logic                             sw_we, hit;
  logic [LG_TLB-1:0]                ent_idx, hit_idx;
  logic [N_ENT-1:0]                 valid_a;
  logic [N_ENT-1:0][VPN_W-1:0]      vpn_a, ppn_a;
  logic [N_ENT-1:0][CTX_BITS-1:0]   ctx_a;
  logic [N_ENT-1:0][3:0]            flags_a;
  logic [31:0]                      rd_vword, rd_pword;
  logic [VPN_W-1:0]                 look_vpn;
  logic                             accept, issue;
  fault_e                           fault;
  logic [31:0]                      ctrl_word, stat_word;

  assign look_vpn = cpu_addr[AW-1:OFF_W];
  assign ent_idx  = ctl_addr[LG_TLB:1];
  assign sw_we    = ctl_stb && ctl_we && ctl_addr[CTL_AW-1];

  tlb_store #(.N_ENT(N_ENT), .IDX_W(LG_TLB), .VPN_W(VPN_W),
              .CLO_W(CLO_W), .CHI_W(CHI_W)) u_store (
    .clk(clk), .arst_n(arst_n),
    .sw_we(sw_we), .sw_phys(ctl_addr[0]), .sw_idx(ent_idx), .sw_wdata(ctl_wdata),
    .ax_set(issue && user_mode), .ax_idx(hit_idx),
    .valid(valid_a), .vpn(vpn_a), .ppn(ppn_a), .ctx(ctx_a), .flags(flags_a),
    .rd_vword(rd_vword), .rd_pword(rd_pword));

  tlb_match #(.N_ENT(N_ENT), .IDX_W(LG_TLB), .VPN_W(VPN_W),
              .CTX_W(CTX_BITS)) u_match (
    .valid(valid_a), .vpn(vpn_a), .ctx(ctx_a),
    .look_vpn(look_vpn), .look_ctx(ctx_q[CTX_BITS-1:0]),
    .hit(hit), .hit_idx(hit_idx));

  assign cpu_stall = stb_q && mem_stall;
  assign accept    = cpu_cyc && cpu_stb && !cpu_stall;

  always_comb begin
    fault = FLT_NONE;
    if (user_mode) begin
      if (!hit)                                   fault = FLT_NOMATCH;
      else if (cpu_we && flags_a[hit_idx][FLAG_RO])    fault = FLT_ROWRITE;
      else if (cpu_fetch && !flags_a[hit_idx][FLAG_EX]) fault = FLT_NOEXEC;
    end
  end
  assign issue = accept && (fault == FLT_NONE);

  always_comb begin
    ctrl_word = {4'(LG_ADDR - 17), 4'(LG_TLB), 4'(LG_PAGE - 10),
                 4'(CTX_BITS - 1), ctx_q};
    stat_word = '0;
    stat_word[LG_PAGE +: VPN_W] = st_vpn_q;
    stat_word[2:0] = st_cause_q;
  end

  // next state
  always_comb begin
    stb_d      = cpu_stall ? stb_q : issue;
    addr_d     = addr_q;
    we_d       = we_q;
    wdat_d     = wdat_q;
    sel_d      = sel_q;
    if (issue) begin
      addr_d = user_mode ? {ppn_a[hit_idx], cpu_addr[OFF_W-1:0]} : cpu_addr;
      we_d   = cpu_we;
      wdat_d = cpu_wdata;
      sel_d  = cpu_sel;
    end
    cyc_d      = cpu_cyc && (cyc_q || issue);
    miss_d     = accept && (fault != FLT_NONE);
    st_vpn_d   = miss_d ? look_vpn : st_vpn_q;
    st_cause_d = miss_d ? fault : st_cause_q;
    ctx_d      = (ctl_stb && ctl_we && ctl_addr == '0) ? ctl_wdata[15:0] : ctx_q;
    cack_d     = ctl_stb;
    crd_d      = crd_q;
    if (ctl_stb) begin
      if (ctl_addr[CTL_AW-1])          crd_d = ctl_addr[0] ? rd_pword : rd_vword;
      else if (ctl_addr == '0)         crd_d = ctrl_word;
      else if (ctl_addr == CTL_AW'(1)) crd_d = stat_word;
      else                             crd_d = '0;
    end
  end

  // registers
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stb_q <= 1'b0; cyc_q <= 1'b0; we_q <= 1'b0; miss_q <= 1'b0;
      addr_q <= '0; wdat_q <= '0; sel_q <= '0; ctx_q <= '0;
      st_vpn_q <= '0; st_cause_q <= '0; cack_q <= 1'b0; crd_q <= '0;
    end else begin
      stb_q <= stb_d; cyc_q <= cyc_d; we_q <= we_d; miss_q <= miss_d;
      addr_q <= addr_d; wdat_q <= wdat_d; sel_q <= sel_d; ctx_q <= ctx_d;
      st_vpn_q <= st_vpn_d; st_cause_q <= st_cause_d;
      cack_q <= cack_d; crd_q <= crd_d;
    end
  end

  assign mem_stb   = stb_q;
  assign mem_cyc   = cyc_q;
  assign mem_we    = we_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = wdat_q;
  assign mem_sel   = sel_q;
  assign cpu_miss  = miss_q;
  assign cpu_ack   = mem_ack && cyc_q;
  assign cpu_err   = mem_err && cyc_q;
  assign cpu_rdata = mem_rdata;
  assign ctl_ack   = cack_q;
  assign ctl_rdata = crd_q;

  AST_KERNEL_PASS: assert property (@(posedge clk) disable iff (!arst_n)
    (accept && !user_mode) |=> (mem_stb && mem_addr == $past(cpu_addr))); // R4
  AST_MISS_NO_STB: assert property (@(posedge clk) disable iff (!arst_n)
    cpu_miss |-> !mem_stb); // R6
  AST_MISS_FROM_USER: assert property (@(posedge clk) disable iff (!arst_n)
    cpu_miss |-> $past(cpu_cyc && cpu_stb && user_mode)); // R6
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!arst_n)
    (mem_stb && mem_stall) |=> (mem_stb && $stable(mem_addr))); // R11
  AST_ACK_GATED: assert property (@(posedge clk) disable iff (!arst_n)
    (cpu_ack || cpu_err) |-> mem_cyc); // R12
  AST_CAUSE_ONEHOT: assert property (@(posedge clk) disable iff (!arst_n)
    $onehot0(st_cause_q)); // R9
  AST_CTL_ACK: assert property (@(posedge clk) disable iff (!arst_n)
    ctl_stb |=> ctl_ack); // R1
endmodule

// File: tb/sim_xlat_mmu.sv
`timescale 1ns/1ps
module sim_xlat_mmu;
  logic        clk, rst_n;
  logic        ctl_stb, ctl_we;
  logic [4:0]  ctl_addr;
  logic [31:0] ctl_wdata, ctl_rdata;
  logic        ctl_ack;
  logic        cpu_cyc, cpu_stb, cpu_we, user_mode, cpu_fetch;
  logic [29:0] cpu_addr, mem_addr;
  logic [31:0] cpu_wdata, cpu_rdata, mem_wdata, mem_rdata;
  logic [3:0]  cpu_sel, mem_sel;
  logic        cpu_stall, cpu_ack, cpu_miss, cpu_err;
  logic        mem_cyc, mem_stb, mem_we, mem_stall, mem_ack, mem_err;

  int n_chk, n_fail;
  bit done;

  xlat_mmu u0 (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check_eq(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [19:0] mv_vpn [8];
  logic [19:0] mv_ppn [8];
  logic [7:0]  mv_clo [8];
  logic [7:0]  mv_chi [8];
  logic [3:0]  mv_flg [8];
  bit          mv_val [8];
  logic [15:0] m_ctx;
  logic [19:0] m_svpn;
  logic [2:0]  m_scause;
  bit          m_stb, m_cyc, m_we, m_miss, m_cack, m_acc;
  logic [29:0] m_addr;
  logic [31:0] m_crd;

  always @(posedge clk) begin : model
    bit stall_now, acc, ok;
    int hit;
    logic [2:0] cause;
    logic [19:0] page;
    logic [31:0] rd;
    int ei;
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) begin
        mv_vpn[i] = 0; mv_ppn[i] = 0; mv_clo[i] = 0; mv_chi[i] = 0;
        mv_flg[i] = 0; mv_val[i] = 0;
      end
      m_ctx = 0; m_svpn = 0; m_scause = 0; m_stb = 0; m_cyc = 0; m_we = 0;
      m_miss = 0; m_cack = 0; m_acc = 0; m_addr = 0; m_crd = 0;
    end else begin
      stall_now = m_stb && mem_stall;
      acc  = cpu_cyc && cpu_stb && !stall_now;
      page = cpu_addr[29:10];
      hit  = -1;
      for (int i = 0; i < 8; i++)
        if (hit < 0 && mv_val[i] && mv_vpn[i] == page && {mv_chi[i], mv_clo[i]} == m_ctx)
          hit = i;
      cause = 3'd0;
      if (user_mode) begin
        if (hit < 0) cause = 3'd1;
        else if (cpu_we && mv_flg[hit][3]) cause = 3'd2;
        else if (cpu_fetch && !mv_flg[hit][2]) cause = 3'd4;
      end
      ok = acc && cause == 3'd0;
      ei = int'(ctl_addr[3:1]);
      rd = 32'h0;
      if (ctl_addr[4]) rd = ctl_addr[0] ? {mv_ppn[ei], mv_chi[ei], 4'h0}
                                        : {mv_vpn[ei], mv_clo[ei], mv_flg[ei]};
      else if (ctl_addr == 5'd0) rd = {4'hF, 4'h3, 4'h2, 4'hF, m_ctx};
      else if (ctl_addr == 5'd1) rd = {m_svpn, 9'h0, m_scause};
      if (!stall_now) begin
        m_stb = ok;
        if (ok) begin
          m_addr = user_mode ? {mv_ppn[hit], cpu_addr[9:0]} : cpu_addr;
          m_we   = cpu_we;
        end
      end
      m_cyc  = cpu_cyc && (m_cyc || ok);
      m_miss = acc && cause != 3'd0;
      if (m_miss) begin m_svpn = page; m_scause = cause; end
      if (ok && user_mode) mv_flg[hit][0] = 1'b1;
      m_cack = ctl_stb;
      if (ctl_stb) m_crd = rd;
      if (ctl_stb && ctl_we) begin
        if (ctl_addr == 5'd0) m_ctx = ctl_wdata[15:0];
        else if (ctl_addr[4] && ctl_addr[0]) begin
          mv_ppn[ei] = ctl_wdata[31:12]; mv_chi[ei] = ctl_wdata[11:4]; mv_val[ei] = 1;
        end else if (ctl_addr[4]) begin
          mv_vpn[ei] = ctl_wdata[31:12]; mv_clo[ei] = ctl_wdata[11:4];
          mv_flg[ei] = ctl_wdata[3:0]; mv_val[ei] = 0;
        end
      end
      m_acc = acc;
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(posedge clk) begin
    #3;
    if (rst_n && !done) begin
      check_eq("R4,R5 mem_stb", 32'(mem_stb), 32'(m_stb));
      if (m_stb) begin
        check_eq("R4,R5 mem_addr", 32'(mem_addr), 32'(m_addr));
        check_eq("R4,R5 mem_we", 32'(mem_we), 32'(m_we));
      end
      check_eq("R12 mem_cyc", 32'(mem_cyc), 32'(m_cyc));
      check_eq("R6,R7,R8 cpu_miss", 32'(cpu_miss), 32'(m_miss));
      check_eq("R11 cpu_stall", 32'(cpu_stall), 32'(m_stb && mem_stall));
      check_eq("R12 cpu_ack", 32'(cpu_ack), 32'(mem_ack && m_cyc));
      check_eq("R12 cpu_err", 32'(cpu_err), 32'(mem_err && m_cyc));
      check_eq("R1 ctl_ack", 32'(ctl_ack), 32'(m_cack));
      if (m_cack) check_eq("R1,R2,R9 ctl_rdata", ctl_rdata, m_crd);
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic ctl_write(input logic [31:0] boff, input logic [31:0] d);
    @(negedge clk);
    ctl_stb = 1; ctl_we = 1; ctl_addr = boff[6:2]; ctl_wdata = d;
    @(negedge clk);
    ctl_stb = 0; ctl_we = 0;
  endtask

  task automatic ctl_read(input logic [31:0] boff, output logic [31:0] d);
    @(negedge clk);
    ctl_stb = 1; ctl_we = 0; ctl_addr = boff[6:2];
    @(negedge clk);
    ctl_stb = 0;
    d = ctl_rdata;
  endtask

  task automatic cpu_one(input bit we, input bit fetch, input bit user,
                         input logic [31:0] baddr, output bit got_miss,
                         output bit got_stb, output logic [29:0] got_addr);
    @(negedge clk);
    user_mode = user; cpu_fetch = fetch; cpu_we = we;
    cpu_cyc = 1; cpu_stb = 1; cpu_addr = baddr[31:2]; cpu_wdata = baddr ^ 32'h5A5A5A5A;
    @(negedge clk);
    cpu_stb = 0;
    got_miss = cpu_miss; got_stb = mem_stb; got_addr = mem_addr;
    mem_ack = we ? 1'b0 : got_stb;
    @(negedge clk);
    mem_ack = 0; cpu_cyc = 0; cpu_fetch = 0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R1 actual=timeout expected=completion");
    finish_run();
  end

  initial begin : main
    logic [31:0] d;
    bit gm, gs;
    logic [29:0] ga;
    int good, k;
    n_chk = 0; n_fail = 0; done = 0;
    rst_n = 0; ctl_stb = 0; ctl_we = 0; ctl_addr = 0; ctl_wdata = 0;
    cpu_cyc = 0; cpu_stb = 0; cpu_we = 0; cpu_addr = 0; cpu_wdata = 0; cpu_sel = 4'hF;
    user_mode = 0; cpu_fetch = 0; mem_stall = 0; mem_ack = 0; mem_err = 0;
    mem_rdata = 32'hC0DE0000;
    repeat (3) @(negedge clk);
    check_eq("R1 reset mem_stb", 32'(mem_stb), 32'h0);
    check_eq("R12 reset mem_cyc", 32'(mem_cyc), 32'h0);
    rst_n = 1;
    repeat (4) @(negedge clk);

    ctl_read(0, d);
    check_eq("R1 control word after reset", d, 32'hF32F0000);
    ctl_write(0, 32'hABCD1234);
    ctl_read(0, d);
    check_eq("R1 control word identifier", d, 32'hF32F1234);

    // entries for identifier 0x1234: low part 0x34, high part 0x12
    ctl_write(64, 32'hFFFFF340); ctl_write(68, 32'h00010120);
    ctl_write(72, 32'h0040034C); ctl_write(76, 32'h00020120);
    ctl_write(80, 32'h00500354); ctl_write(84, 32'h00030120);
    ctl_write(88, 32'h00400340); ctl_write(92, 32'h00040120);
    ctl_write(96, 32'h00600340);
    ctl_read(64, d); check_eq("R2 entry0 virtual word", d, 32'hFFFFF340);
    ctl_read(68, d); check_eq("R2 entry0 physical word", d, 32'h00010120);

    cpu_one(0, 0, 0, 32'h12345678, gm, gs, ga);
    check_eq("R4 kernel passthrough addr", 32'(ga), 32'h048D159E);
    check_eq("R4 kernel no miss", 32'(gm), 32'h0);

    cpu_one(0, 0, 1, 32'hFFFFFFFC, gm, gs, ga);
    check_eq("R5 user hit addr", 32'(ga), 32'h000043FF);
    ctl_read(64, d); check_eq("R10 accessed flag set", d, 32'hFFFFF341);

    cpu_one(1, 0, 1, 32'h00400010, gm, gs, ga);
    check_eq("R7 read-only write miss", 32'(gm), 32'h1);
    check_eq("R7 no strobe", 32'(gs), 32'h0);
    ctl_read(4, d); check_eq("R9 status read-only", d, 32'h00400002);

    cpu_one(0, 1, 1, 32'hFFFFF010, gm, gs, ga);
    check_eq("R8 no-exec fetch miss", 32'(gm), 32'h1);
    ctl_read(4, d); check_eq("R9 status no-exec", d, 32'hFFFFF004);

    cpu_one(0, 1, 1, 32'h00400010, gm, gs, ga);
    check_eq("R5 lowest index wins", 32'(ga), 32'h00008004);
    check_eq("R8 read-only page readable", 32'(gm), 32'h0);

    cpu_one(0, 0, 1, 32'h00500020, gm, gs, ga);
    check_eq("R6 identifier mismatch miss", 32'(gm), 32'h1);
    ctl_read(4, d); check_eq("R9 status no-match", d, 32'h00500001);

    cpu_one(0, 0, 1, 32'h00600000, gm, gs, ga);
    check_eq("R3 invalid entry miss", 32'(gm), 32'h1);
    check_eq("R6 mem_cyc stays closed", 32'(mem_cyc), 32'h0);
    ctl_write(100, 32'h00060120);
    cpu_one(0, 0, 1, 32'h00600008, gm, gs, ga);
    check_eq("R3 entry valid after physical write", 32'(ga), 32'h00018002);

    // unstalled same-page burst: one per clock
    @(negedge clk);
    user_mode = 1; cpu_we = 0; cpu_cyc = 1; cpu_stb = 1; cpu_addr = 30'h3FFFFC00;
    good = 0;
    for (int i = 1; i <= 4; i++) begin
      @(negedge clk);
      if (mem_stb && mem_addr == 30'h00004000 + 30'(i - 1)) good++;
      if (i < 4) cpu_addr = 30'h3FFFFC00 + 30'(i); else cpu_stb = 0;
    end
    check_eq("R11 one request per clock", 32'(good), 32'd4);
    @(negedge clk); cpu_cyc = 0;
    @(negedge clk);

    // stalled write burst with acks and an error
    @(negedge clk);
    cpu_we = 1; cpu_cyc = 1; cpu_stb = 1; cpu_addr = 30'h3FFFFC10; cpu_wdata = 32'h11;
    k = 0;
    for (int c = 0; c < 30 && k < 6; c++) begin
      @(negedge clk);
      if (m_acc) k++;
      mem_stall = (c == 2 || c == 3);
      mem_ack = (c == 1 || c == 5);
      mem_err = (c == 6);
      if (k < 6) begin cpu_addr = 30'h3FFFFC10 + 30'(k); cpu_wdata = 32'(k); end
      else cpu_stb = 0;
    end
    cpu_stb = 0;
    @(negedge clk); mem_stall = 0; mem_ack = 1; mem_err = 0;
    @(negedge clk); mem_ack = 0; cpu_cyc = 0; cpu_we = 0;
    @(negedge clk);
    check_eq("R12 mem_cyc closed after cyc drop", 32'(mem_cyc), 32'h0);

    // same-cycle hit and software rewrite of entry 0
    @(negedge clk);
    ctl_stb = 1; ctl_we = 1; ctl_addr = 5'd16; ctl_wdata = 32'hFFFFF340;
    user_mode = 1; cpu_cyc = 1; cpu_stb = 1; cpu_addr = 30'h3FFFFC04;
    @(negedge clk);
    ctl_stb = 0; ctl_we = 0; cpu_stb = 0;
    check_eq("R10 hit issued in overlap cycle", 32'(mem_stb), 32'h1);
    @(negedge clk); cpu_cyc = 0;
    ctl_read(64, d); check_eq("R10 software write wins", d, 32'hFFFFF340);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule